// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the bus-side command interpreter of a byte-wide 128 KB parallel NOR flash, together with a behavioural array that stands in for the storage cells. It watches every bus write. A two-write unlock followed by a command write selects an operation: byte program, whole-array erase, 4 KB sector erase, or entry to and exit from a mode where reads return identification bytes instead of array data. Erase needs an extra arming command that goes through its own unlock. The erase itself takes a second unlock sequence.

Erases are carried out as a sweep that writes 0xFF into one byte per clock. While the sweep runs, `busy` is high, bus writes are dropped and reads return 0xFF. Reads have one clock of latency and the read data holds between reads. The physical array has `2**ARRAY_AW` bytes (8 KB by default, two sectors). Higher addresses fold onto it modulo the array size, so "whole array" means every physical byte.

Sequencer states: `SEQ_IDLE` (waiting for an unlock or a bare exit byte), `SEQ_GOT_AA` (first unlock write seen), `SEQ_GOT_55` (second unlock write seen, the next write is the command), and `SEQ_PROG` (the next write is stored). Transitions: IDLE→GOT_AA on 0xAA at 0x5555. GOT_AA→GOT_55 on 0x55 at 0x2AAA, otherwise back to IDLE. GOT_55→PROG on command 0xA0, and GOT_55→IDLE on any other third write. PROG→IDLE on any write. A 0xF0 write in IDLE stays in IDLE and clears ID mode.

Top module: `nor_flash_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0xFF, the sequencer is idle with ID mode and erase arming cleared. Array byte `a` holds its preload value `a[7:0] XOR a[15:8]`.
- R2: The unlock sequence is 0xAA written to 0x5555 and then 0x55 written to 0x2AAA. Only address bits 15:0 are compared, so bit 16 is ignored. Any write that does not match returns the sequencer to idle.
- R3: Command 0xA0 written to 0x5555 after an unlock arms a program. The next write, at any address, stores its data at that address modulo the array size, and the sequencer returns to idle.
- R4: Command 0x80 sets the erase-arm flag and returns to idle. Arming alone changes no array byte and does not raise `busy`.
- R5: Command 0x10 at 0x5555 with erase armed fills the whole array with 0xFF. Without arming it has no effect.
- R6: With erase armed, a third write of 0x30 at any address other than 0x5555 fills the 4 KB sector picked by the address bits above bit 11 with 0xFF. Other sectors are untouched. Arming stays set afterwards, so a further sector erase needs only an unlock.
- R7: Command 0x90 enters ID mode. In ID mode, a read whose low 16 address bits are 0x0000 returns 0xBF, 0x0001 returns 0xB5, and any other address returns 0xFF.
- R8: Command 0xF0 after an unlock leaves ID mode. A bare 0xF0 write while idle also leaves ID mode, with no unlock.
- R9: Every command other than 0x80 clears erase arming. Unrecognised commands only return the sequencer to idle.
- R10: An erase raises `busy` from the clock after the command write. `busy` stays high for exactly 4096 cycles for a sector and `2**ARRAY_AW` cycles for the whole array. While `busy` is high, bus writes are ignored and reads return 0xFF.
- R11: `rd_data` updates on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (17) | Byte address for reads and writes |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Erase sweep in progress |

## Verification
The assertions assume that each bus write is a single-cycle `wr_en` pulse and that `wr_en` and `rd_en` are never both high in one cycle. The stimulus drives every access as a one-cycle strobe on the falling edge, with idle gaps between accesses. They also assume that software only issues a command when `busy` is low. The bench issues writes during a sweep only on purpose, to check that they are ignored, and it waits for `busy` to fall before starting any real sequence. Address bit 16 and addresses beyond the physical array are driven deliberately, to exercise the 16-bit compare and the folding onto the array.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_GOT_AA = 2'd1,
        SEQ_GOT_55 = 2'd2,
        SEQ_PROG   = 2'd3
    } seq_state_e;

    // Unlock addresses, compared on the low 16 address bits
    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;

    localparam byte_t KEY_FIRST  = 8'hAA;
    localparam byte_t KEY_SECOND = 8'h55;

    localparam byte_t OP_PROGRAM = 8'hA0;
    localparam byte_t OP_ARM     = 8'h80;
    localparam byte_t OP_WHOLE   = 8'h10;
    localparam byte_t OP_SECTOR  = 8'h30;
    localparam byte_t OP_ID_ON   = 8'h90;
    localparam byte_t OP_ID_OFF  = 8'hF0;

    localparam byte_t MAKER_CODE  = 8'hBF;
    localparam byte_t DEVICE_CODE = 8'hB5;
    localparam byte_t BLANK_BYTE  = 8'hFF;

    // Preload pattern of the array model: low byte XOR next byte of the address
    function automatic byte_t preload_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

endpackage

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output seq_state_e        state_q,
    output logic              id_mode_q,
    output logic              arm_q,
    output logic              prog_we,
    output logic              erase_go,
    output logic              erase_whole
);

    localparam logic [CMP_W-1:0] MATCH_A = UNLOCK_ADDR_A[CMP_W-1:0];
    localparam logic [CMP_W-1:0] MATCH_B = UNLOCK_ADDR_B[CMP_W-1:0];

    seq_state_e       state_d;
    logic             id_mode_d;
    logic             arm_d;
    logic             wr_act;
    logic             at_a;
    logic             at_b;
    logic [CMP_W-1:0] low_addr;

    assign low_addr = addr[CMP_W-1:0];
    assign wr_act   = wr_en && !busy;
    assign at_a     = (low_addr == MATCH_A);
    assign at_b     = (low_addr == MATCH_B);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            id_mode_q <= 1'b0;
            arm_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            id_mode_q <= id_mode_d;
            arm_q     <= arm_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        id_mode_d   = id_mode_q;
        arm_d       = arm_q;
        prog_we     = 1'b0;
        erase_go    = 1'b0;
        erase_whole = 1'b0;
        if (wr_act) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (wdata == OP_ID_OFF) begin
                        id_mode_d = 1'b0;
                    end else if (at_a && wdata == KEY_FIRST) begin
                        state_d = SEQ_GOT_AA;
                    end
                end
                SEQ_GOT_AA: begin
                    state_d = (at_b && wdata == KEY_SECOND) ? SEQ_GOT_55 : SEQ_IDLE;
                end
                SEQ_GOT_55: begin
                    state_d = SEQ_IDLE;
                    if (at_a) begin
                        arm_d = 1'b0;
                        case (wdata)
                            OP_ARM:     arm_d = 1'b1;
                            OP_WHOLE: begin
                                erase_go    = arm_q;
                                erase_whole = arm_q;
                            end
                            OP_ID_ON:   id_mode_d = 1'b1;
                            OP_ID_OFF:  id_mode_d = 1'b0;
                            OP_PROGRAM: state_d = SEQ_PROG;
                            default: ;
                        endcase
                    end else if (wdata == OP_SECTOR && arm_q) begin
                        erase_go = 1'b1;
                    end
                end
                SEQ_PROG: begin
                    prog_we = 1'b1;
                    state_d = SEQ_IDLE;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nfc_erase_sweep.sv
module nfc_erase_sweep #(
    parameter int ARRAY_AW  = 13,
    parameter int SECTOR_AW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic                          whole,
    input  logic [ARRAY_AW-SECTOR_AW-1:0] sector_sel,
    output logic                          busy,
    output logic [ARRAY_AW-1:0]           wipe_addr
);

    localparam int               LEN_W      = ARRAY_AW + 1;
    localparam logic [LEN_W-1:0] WHOLE_LEN  = LEN_W'(1) << ARRAY_AW;
    localparam logic [LEN_W-1:0] SECTOR_LEN = LEN_W'(1) << SECTOR_AW;

    logic [ARRAY_AW-1:0] ptr_q;
    logic [LEN_W-1:0]    left_q;

    assign busy      = (left_q != '0);
    assign wipe_addr = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            left_q <= '0;
        end else if (busy) begin
            ptr_q  <= ptr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end else if (go) begin
            ptr_q  <= whole ? '0 : {sector_sel, {SECTOR_AW{1'b0}}};
            left_q <= whole ? WHOLE_LEN : SECTOR_LEN;
        end
    end

endmodule

// File: rtl/nfc_array.sv
module nfc_array
    import nfc_pkg::*;
#(
    parameter int ARRAY_AW = 13
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ARRAY_AW-1:0] waddr,
    input  byte_t               wdata,
    input  logic                re,
    input  logic [ARRAY_AW-1:0] raddr,
    output byte_t               rdata
);

    localparam int DEPTH = 1 << ARRAY_AW;

    byte_t cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i] = preload_byte(32'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/nor_flash_cmd_seq.sv
module nor_flash_cmd_seq
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int CMP_W     = 16,
    parameter int ARRAY_AW  = 13,
    parameter int SECTOR_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int SEL_W = ARRAY_AW - SECTOR_AW;

    seq_state_e          seq_state;
    logic                id_mode;
    logic                erase_arm;
    logic                prog_we;
    logic                erase_go;
    logic                erase_whole;
    logic [ARRAY_AW-1:0] wipe_addr;
    logic                mem_we;
    logic [ARRAY_AW-1:0] mem_waddr;
    byte_t               mem_wdata;
    byte_t               mem_rdata;
    byte_t               id_byte;
    logic                use_array_q;
    byte_t               fixed_q;

    nfc_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .CMP_W  (CMP_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .busy        (busy),
        .addr        (addr),
        .wdata       (wdata),
        .state_q     (seq_state),
        .id_mode_q   (id_mode),
        .arm_q       (erase_arm),
        .prog_we     (prog_we),
        .erase_go    (erase_go),
        .erase_whole (erase_whole)
    );

    nfc_erase_sweep #(
        .ARRAY_AW  (ARRAY_AW),
        .SECTOR_AW (SECTOR_AW)
    ) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (erase_go),
        .whole      (erase_whole),
        .sector_sel (addr[ARRAY_AW-1 -: SEL_W]),
        .busy       (busy),
        .wipe_addr  (wipe_addr)
    );

    // Sweep and program never coincide: program is gated by busy
    assign mem_we    = busy || prog_we;
    assign mem_waddr = busy ? wipe_addr : addr[ARRAY_AW-1:0];
    assign mem_wdata = busy ? BLANK_BYTE : wdata;

    nfc_array #(
        .ARRAY_AW (ARRAY_AW)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (rd_en),
        .raddr (addr[ARRAY_AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        unique case (addr[CMP_W-1:0])
            CMP_W'(0): id_byte = MAKER_CODE;
            CMP_W'(1): id_byte = DEVICE_CODE;
            default:   id_byte = BLANK_BYTE;
        endcase
    end

    // Read source selection, captured with the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_array_q <= 1'b0;
            fixed_q     <= BLANK_BYTE;
        end else if (rd_en) begin
            use_array_q <= !busy && !id_mode;
            fixed_q     <= busy ? BLANK_BYTE : id_byte;
        end
    end

    assign rd_data = use_array_q ? mem_rdata : fixed_q;

endmodule

// File: rtl/nfc_checker.sv
module nfc_checker
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              busy,
    input seq_state_e        seq_state,
    input logic              id_mode,
    input logic              erase_arm
);

    // R10
    busy_read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_en |=> rd_data == 8'hFF);

    // R10
    busy_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_en |=> $stable(seq_state) && $stable(id_mode) && $stable(erase_arm));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    maker_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && id_mode && rd_en && addr[15:0] == 16'h0000 |=> rd_data == 8'hBF);

    // R3
    program_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SEQ_PROG && wr_en && !busy |=> seq_state == SEQ_IDLE);

    // R4
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SEQ_GOT_55 && wr_en && !busy && addr[15:0] == 16'h5555 && wdata == 8'h80
        |=> erase_arm && seq_state == SEQ_IDLE);

    // R8
    bare_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == SEQ_IDLE && wr_en && !busy && wdata == 8'hF0 |=> !id_mode);

endmodule

bind nor_flash_cmd_seq nfc_checker #(.ADDR_W(ADDR_W)) u_nfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .busy      (busy),
    .seq_state (seq_state),
    .id_mode   (id_mode),
    .erase_arm (erase_arm)
);

// File: tb/nor_flash_cmd_seq_bench.sv
module nor_flash_cmd_seq_bench;

    localparam int DEPTH = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nor_flash_cmd_seq u_nor_flash_cmd_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .busy    (busy)
    );

    function automatic logic [7:0] pre(int a);
        return 8'(a & 255) ^ 8'((a >> 8) & 255);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [DEPTH];
    int         m_phase;      // 0 idle, 1 saw AA, 2 saw 55, 3 program next
    bit         m_id;
    bit         m_arm;
    int         m_left;
    logic [7:0] m_rd;

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = pre(i);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_id = 0; m_arm = 0; m_left = 0; m_rd = 8'hFF;
        end else begin
            int a;
            int lo;
            a  = int'(addr);
            lo = a & 16'hFFFF;
            if (rd_en) begin
                if (m_left > 0)      m_rd = 8'hFF;
                else if (m_id)       m_rd = (lo == 0) ? 8'hBF : (lo == 1) ? 8'hB5 : 8'hFF;
                else                 m_rd = m_mem[a % DEPTH];
            end
            if (m_left > 0) begin
                m_left--;
            end else if (wr_en) begin
                case (m_phase)
                    0: begin
                        if (wdata == 8'hF0) m_id = 0;
                        else if (lo == 16'h5555 && wdata == 8'hAA) m_phase = 1;
                    end
                    1: m_phase = (lo == 16'h2AAA && wdata == 8'h55) ? 2 : 0;
                    2: begin
                        m_phase = 0;
                        if (lo == 16'h5555) begin
                            bit was_armed;
                            was_armed = m_arm;
                            m_arm = 0;
                            if (wdata == 8'h80) m_arm = 1;
                            else if (wdata == 8'h90) m_id = 1;
                            else if (wdata == 8'hF0) m_id = 0;
                            else if (wdata == 8'hA0) m_phase = 3;
                            else if (wdata == 8'h10 && was_armed) begin
                                for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                                m_left = DEPTH;
                            end
                        end else if (wdata == 8'h30 && m_arm) begin
                            int base;
                            base = (a % DEPTH) & ~4095;
                            for (int i = 0; i < 4096; i++) m_mem[base + i] = 8'hFF;
                            m_left = 4096;
                        end
                    end
                    default: begin
                        m_mem[a % DEPTH] = wdata;
                        m_phase = 0;
                    end
                endcase
            end
        end
    end

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 busy per-cycle", {31'b0, busy}, {31'b0, (m_left > 0)});
            check("R11 rd_data per-cycle", {24'b0, rd_data}, {24'b0, m_rd});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, logic [7:0] d);
        addr = 17'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(string tag, int a, logic [7:0] exp);
        addr = 17'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {24'b0, rd_data}, {24'b0, exp});
    endtask

    task automatic unlock();
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
    endtask

    task automatic cmd(logic [7:0] c);
        unlock();
        wr(16'h5555, c);
    endtask

    task automatic measure_busy(string tag, int exp_len);
        int cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        check(tag, 32'(cnt), 32'(exp_len));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and preload
        check("R1 busy after reset", {31'b0, busy}, 32'd0);
        check("R1 rd_data after reset", {24'b0, rd_data}, 32'hFF);
        rd("R1 preload 0x0123", 16'h0123, 8'h22);
        rd("R1 preload 0x1FFF", 16'h1FFF, 8'hE0);

        // R3 byte program
        cmd(8'hA0);
        wr(16'h0040, 8'h5A);
        rd("R3 programmed byte", 16'h0040, 8'h5A);
        // R11 hold between reads
        repeat (3) @(negedge clk);
        check("R11 rd_data holds", {24'b0, rd_data}, 32'h5A);

        // R2 bit 16 ignored in compare
        wr(17'h15555, 8'hAA);
        wr(17'h12AAA, 8'h55);
        wr(17'h15555, 8'hA0);
        wr(16'h0041, 8'h3C);
        rd("R2 upper bit ignored", 16'h0041, 8'h3C);

        // R2 mismatched second write aborts
        wr(16'h5555, 8'hAA);
        wr(16'h2AAB, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0042, 8'h00);
        rd("R2 mismatch aborts", 16'h0042, pre(16'h0042));

        // R9 unknown command returns to idle
        cmd(8'h77);
        wr(16'h0043, 8'h11);
        rd("R9 unknown command", 16'h0043, pre(16'h0043));

        // R7 ID mode
        cmd(8'h90);
        rd("R7 maker code", 16'h0000, 8'hBF);
        rd("R7 device code via bit16", 17'h10001, 8'hB5);
        rd("R7 other address", 16'h0002, 8'hFF);
        rd("R7 array hidden", 16'h0040, 8'hFF);

        // R8 command exit and bare exit
        cmd(8'hF0);
        rd("R8 command exit", 16'h0040, 8'h5A);
        cmd(8'h90);
        rd("R8 back in ID", 16'h0000, 8'hBF);
        wr(16'h1234, 8'hF0);
        rd("R8 bare exit", 16'h0040, 8'h5A);

        // R5 whole erase without arming
        cmd(8'h10);
        check("R5 unarmed no busy", {31'b0, busy}, 32'd0);
        rd("R5 unarmed keeps data", 16'h0040, 8'h5A);

        // R4 arming alone
        cmd(8'h80);
        check("R4 arm no busy", {31'b0, busy}, 32'd0);
        rd("R4 arm keeps data", 16'h0040, 8'h5A);

        // R9 another command disarms
        cmd(8'h90);
        cmd(8'hF0);
        cmd(8'h10);
        check("R9 disarmed no busy", {31'b0, busy}, 32'd0);
        rd("R9 disarmed keeps data", 16'h0040, 8'h5A);

        // R6 sector erase of sector 0
        cmd(8'hA0);
        wr(16'h1005, 8'h77);
        rd("R3 sector1 byte", 16'h1005, 8'h77);
        cmd(8'h80);
        unlock();
        wr(16'h0800, 8'h30);
        check("R10 busy after sector cmd", {31'b0, busy}, 32'd1);
        measure_busy("R10 sector sweep length", 4096);
        rd("R6 sector0 erased", 16'h0040, 8'hFF);
        rd("R6 sector0 erased other", 16'h0123, 8'hFF);
        rd("R6 sector1 kept", 16'h1005, 8'h77);
        rd("R6 sector1 preload kept", 16'h1FFF, 8'hE0);

        // R6 arming persists; R10 writes dropped while busy
        unlock();
        wr(16'h1800, 8'h30);
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0050, 8'h12);
        rd("R10 read while busy", 16'h1005, 8'hFF);
        measure_busy("R10 second sector length", 4096 - 5);
        rd("R10 dropped program", 16'h0050, 8'hFF);
        wr(16'h0050, 8'h34);
        rd("R10 sequencer stayed idle", 16'h0050, 8'hFF);
        rd("R6 second sector erased", 16'h1005, 8'hFF);

        // R5 whole erase
        cmd(8'hA0);
        wr(16'h0060, 8'h99);
        rd("R3 byte before whole erase", 16'h0060, 8'h99);
        wr(16'h0000, 8'h00);
        cmd(8'h80);
        cmd(8'h10);
        measure_busy("R10 whole sweep length", DEPTH);
        rd("R5 whole erased low", 16'h0060, 8'hFF);
        rd("R5 whole erased high", 16'h1FFF, 8'hFF);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule